// File: doc/BRIEF.md
# I2C SCL timing generator

This block paces the clock line of an I2C master in standard, fast and fast-plus modes. Three programmable values set the timing. The first is a 16-bit baud count, B. The second is a 2-bit speed mode. The third is a post-stretch setup count, N. From these the block drives the SCL output enable and emits single-cycle phase strobes for the transaction sequencer: one at the start of the low phase, one at the start of the high phase, and one at the data sample point.

In standard mode the low and high phases each last B system clock cycles. In fast and fast-plus modes the low phase lasts 2B cycles and the high phase B cycles. A slave may hold SCL low after the master has released it. While that happens the high-phase count is frozen. Once the line is seen high again, the block waits N+1 system clock cycles before the high-phase count continues. The sequencer drives the software-visible registers through a simple write port. A baud count of zero parks the line released and stops all strobes.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset the baud count, mode and setup count are all zero, `sclOut` is 1 (released) and no strobe is asserted.
- R2: While the baud count is zero, `sclOut` stays 1 and no strobe fires. Writing zero to the baud count while a period is in progress parks the line released from the second clock edge after the write.
- R3: In mode 0 (standard), with no stretching, SCL is low for B cycles and then released for B cycles, so the period is 2B cycles.
- R4: In mode 1 (fast) and mode 3 (fast plus), with no stretching, SCL is low for 2B cycles and released for B cycles, so the period is 3B cycles.
- R5: Mode 2 (high speed, not supported) produces standard-mode timing.
- R6: `lowStart` pulses for exactly one cycle, on the first cycle that SCL is driven low. `highStart` pulses for exactly one cycle, on the first cycle that SCL is released. Each fires once per period.
- R7: `samplePt` fires once per high phase, while `sclIn` is high, on the cycle at which floor(B/2) counted high cycles have already elapsed.
- R8: If `sclIn` is low while SCL is released, the high count is frozen and no sample fires. Once `sclIn` is seen high, exactly N+1 setup cycles pass before the high count resumes. With H held cycles starting at the first high cycle, the high phase lasts 1+H+(N+1)+B cycles and the sample falls at high-cycle index 1+H+(N+1)+floor(B/2).
- R9: A setup count of zero still inserts one setup cycle after stretching.
- R10: A write takes its field by select code: code 0 takes the baud count from data bits 15:0, code 1 takes the mode from data bits 1:0, and code 2 takes the setup count from data bits 31:16. Every other data bit of the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 baud, 1 mode, 2 setup |
| wrData | input | 32 | Write data |
| sclIn | input | 1 | Synchronized level of the SCL line |
| sclOut | output | 1 | SCL drive: 0 pulls low, 1 releases |
| lowStart | output | 1 | First cycle of the low phase |
| highStart | output | 1 | First cycle of the high phase |
| samplePt | output | 1 | Data sample point in the high phase |

## Verification
The assertions take `sclIn` to be an already synchronized, wired-AND view of the line. They assume it is never high while the block drives SCL low, and that it rises only when a holding slave lets go. The bench meets this by modelling the line as `sclOut` ANDed with a slave-hold signal. The hold signal is asserted only during a released phase. The bench also writes only select codes 0 to 2. It clears the baud count before changing the mode, so that every measured period starts from a clean low phase.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  localparam int MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_STD      = 2'd0;
  localparam logic [MODE_W-1:0] MODE_FAST     = 2'd1;
  localparam logic [MODE_W-1:0] MODE_HS       = 2'd2;
  localparam logic [MODE_W-1:0] MODE_FASTPLUS = 2'd3;

  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_BAUD  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_MODE  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_SETUP = 2'd2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH,
    PH_HOLD,
    PH_SETUP
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic setClr;
    logic setInc;
  } dpCtrl_t;

  // datapath -> control
  typedef struct packed {
    logic baudZero;
    logic lowDone;
    logic highDone;
    logic setDone;
    logic atFirst;
    logic atSample;
  } dpStat_t;
endpackage

// File: rtl/i2c_scl_dp.sv
module i2c_scl_dp
  import i2c_scl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BAUD_W  = 16,
  parameter int SETUP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  dpCtrl_t           ctrl,
  output dpStat_t           stat
);
  localparam int CNT_W     = BAUD_W + 1;
  localparam int SETUP_LSB = DATA_W - SETUP_W;

  logic [BAUD_W-1:0]  baudReg;
  logic [MODE_W-1:0]  modeReg;
  logic [SETUP_W-1:0] setupReg;
  logic [CNT_W-1:0]   phaseCnt;
  logic [SETUP_W-1:0] setCnt;
  logic [CNT_W-1:0]   lowLen;
  logic [CNT_W-1:0]   highLen;
  logic               wideLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baudReg  <= '0;
      modeReg  <= MODE_STD;
      setupReg <= '0;
    end else if (wrEn) begin
      case (wrSel)
        SEL_BAUD:  baudReg  <= wrData[BAUD_W-1:0];
        SEL_MODE:  modeReg  <= wrData[MODE_W-1:0];
        SEL_SETUP: setupReg <= wrData[SETUP_LSB +: SETUP_W];
        default:   ;
      endcase
    end
  end

  // fast and fast-plus stretch the low phase to two baud counts
  assign wideLow = (modeReg == MODE_FAST) || (modeReg == MODE_FASTPLUS);
  assign highLen = {1'b0, baudReg};
  assign lowLen  = wideLow ? {baudReg, 1'b0} : highLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      setCnt   <= '0;
    end else begin
      if (ctrl.cntClr)      phaseCnt <= '0;
      else if (ctrl.cntInc) phaseCnt <= phaseCnt + 1'b1;
      if (ctrl.setClr)      setCnt   <= '0;
      else if (ctrl.setInc) setCnt   <= setCnt + 1'b1;
    end
  end

  always_comb begin
    stat.baudZero = (baudReg == '0);
    stat.lowDone  = (phaseCnt >= lowLen - 1'b1);
    stat.highDone = (phaseCnt >= highLen - 1'b1);
    stat.setDone  = (setCnt >= setupReg);
    stat.atFirst  = (phaseCnt == '0);
    stat.atSample = (phaseCnt == (highLen >> 1));
  end
endmodule

// File: rtl/i2c_scl_ctrl.sv
module i2c_scl_ctrl
  import i2c_scl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    sclOut,
  output logic    lowStart,
  output logic    highStart,
  output logic    samplePt
);
  phase_e phase, phaseNxt;
  logic   stretched;

  always_comb begin
    phaseNxt = phase;
    ctrl     = '0;
    if (stat.baudZero) begin
      phaseNxt    = PH_IDLE;
      ctrl.cntClr = 1'b1;
    end else begin
      case (phase)
        PH_IDLE: begin
          phaseNxt    = PH_LOW;
          ctrl.cntClr = 1'b1;
        end
        PH_LOW: begin
          if (stat.lowDone) begin
            phaseNxt    = PH_HIGH;
            ctrl.cntClr = 1'b1;
          end else begin
            ctrl.cntInc = 1'b1;
          end
        end
        PH_HIGH: begin
          if (!sclIn) begin
            phaseNxt = PH_HOLD;          // slave stretching: freeze count
          end else if (stat.highDone) begin
            phaseNxt    = PH_LOW;
            ctrl.cntClr = 1'b1;
          end else begin
            ctrl.cntInc = 1'b1;
          end
        end
        PH_HOLD: begin
          if (sclIn) begin
            phaseNxt    = PH_SETUP;
            ctrl.setClr = 1'b1;
          end
        end
        PH_SETUP: begin
          if (stat.setDone) phaseNxt = PH_HIGH;
          else              ctrl.setInc = 1'b1;
        end
        default: phaseNxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      stretched <= 1'b0;
    end else begin
      phase <= phaseNxt;
      if (phase == PH_LOW)         stretched <= 1'b0;
      else if (phaseNxt == PH_HOLD) stretched <= 1'b1;
    end
  end

  assign sclOut    = (phase != PH_LOW);
  assign lowStart  = (phase == PH_LOW) && stat.atFirst;
  assign highStart = (phase == PH_HIGH) && stat.atFirst && !stretched;
  assign samplePt  = (phase == PH_HIGH) && sclIn && stat.atSample;
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BAUD_W  = 16,
  parameter int SETUP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sclIn,
  output logic              sclOut,
  output logic              lowStart,
  output logic              highStart,
  output logic              samplePt
);
  dpCtrl_t ctrl;
  dpStat_t stat;

  i2c_scl_dp #(
    .DATA_W (DATA_W),
    .BAUD_W (BAUD_W),
    .SETUP_W(SETUP_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrSel (wrSel),
    .wrData(wrData),
    .ctrl  (ctrl),
    .stat  (stat)
  );

  i2c_scl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .stat     (stat),
    .ctrl     (ctrl),
    .sclOut   (sclOut),
    .lowStart (lowStart),
    .highStart(highStart),
    .samplePt (samplePt)
  );
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  wrSel,
  input logic [15:0] wrBaud,
  input logic        sclIn,
  input logic        sclOut,
  input logic        lowStart,
  input logic        highStart,
  input logic        samplePt
);
  AST_RESET_RELEASED: assert property (@(posedge clk) !rstN |=> sclOut); // R1

  AST_BAUD_ZERO_PARKS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0 && wrBaud == 16'd0) |-> ##2
    (sclOut && !lowStart && !highStart && !samplePt)); // R2

  AST_FALL_MARKS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOut) |-> lowStart); // R6

  AST_LOW_NO_HIGH_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    !sclOut |-> (!samplePt && !highStart)); // R6

  AST_LOWSTART_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    lowStart |-> !sclOut); // R6

  AST_SAMPLE_ON_HIGH_LINE: assert property (@(posedge clk) disable iff (!rstN)
    samplePt |-> (sclOut && sclIn)); // R7

  AST_RELEASE_STARTS_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclIn) && sclOut && $past(sclOut)) |-> (!samplePt && !highStart)); // R8
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrSel    (wrSel),
  .wrBaud   (wrData[15:0]),
  .sclIn    (sclIn),
  .sclOut   (sclOut),
  .lowStart (lowStart),
  .highStart(highStart),
  .samplePt (samplePt)
);

// File: tb/i2c_scl_timer_tb.sv
`timescale 1ns/1ps
module i2c_scl_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic        hold = 1'b0;
  logic        sclIn;
  logic        sclOut, lowStart, highStart, samplePt;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  assign sclIn = sclOut & ~hold;   // wired-AND line with a holding slave

  i2c_scl_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .sclIn(sclIn), .sclOut(sclOut), .lowStart(lowStart),
    .highStart(highStart), .samplePt(samplePt)
  );

  // mode, baud, expected low, expected high, expected sample index
  localparam int NVEC = 8;
  localparam int VEC [NVEC][5] = '{
    '{0, 4, 4, 4, 2},     // R3
    '{0, 1, 1, 1, 0},     // R3
    '{1, 4, 8, 4, 2},     // R4
    '{3, 5, 10, 5, 2},    // R4
    '{2, 3, 3, 3, 1},     // R5
    '{1, 1, 2, 1, 0},     // R4
    '{0, 7, 7, 7, 3},     // R3
    '{3, 2, 4, 2, 1}      // R4
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // measures one full period starting at the next lowStart
  task automatic measure(output int lo, output int hi, output int hsIdx,
                         output int spIdx, output int nHs, output int nSp,
                         output int nLs);
    int g;
    lo = 0; hi = 0; hsIdx = -1; spIdx = -1; nHs = 0; nSp = 0; nLs = 0;
    g = 0;
    while (!lowStart && g < 5000) begin @(negedge clk); g++; end
    do begin
      if (lowStart) nLs++;
      if (!sclOut) lo++;
      else begin
        if (highStart) begin hsIdx = hi; nHs++; end
        if (samplePt)  begin spIdx = hi; nSp++; end
        hi++;
      end
      @(negedge clk);
      g++;
    end while (!lowStart && g < 5000);
  endtask

  task automatic stretchTest(input int setupN, input int holdN, input string req);
    int idx, spIdx, nSp, nHs, g;
    bit sawLow, sawSampleHeld;
    int baud = 4;
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd0);
    wr(2'd2, {setupN[15:0], 16'hFFFF});   // R10: low half ignored
    wr(2'd0, baud);
    g = 0;
    while (!highStart && g < 5000) begin @(negedge clk); g++; end
    idx = 0; spIdx = -1; nSp = 0; nHs = 1; sawLow = 0; sawSampleHeld = 0;
    hold = 1'b1;
    for (int k = 0; k < holdN; k++) begin
      @(negedge clk);
      idx++;
      if (!sclOut) sawLow = 1;
      if (samplePt) sawSampleHeld = 1;
    end
    hold = 1'b0;
    forever begin
      @(negedge clk);
      g++;
      if (lowStart || g > 5000) break;
      idx++;
      if (!sclOut) sawLow = 1;
      if (samplePt) begin spIdx = idx; nSp++; end
      if (highStart) nHs++;
    end
    check(idx + 1 == 1 + holdN + setupN + 1 + baud, req, "stretched high length",
          idx + 1, 1 + holdN + setupN + 1 + baud);
    check(spIdx == 1 + holdN + setupN + 1 + baud / 2, req, "sample index after stretch",
          spIdx, 1 + holdN + setupN + 1 + baud / 2);
    check(!sawLow, "R8", "sclOut stays released while held", sawLow, 0);
    check(!sawSampleHeld && nSp == 1, "R8", "single sample, none while held", nSp, 1);
    check(nHs == 1, "R6", "highStart once across stretch", nHs, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int lo, hi, hsIdx, spIdx, nHs, nSp, nLs, strobes;
    string tag;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(sclOut == 1'b1, "R1", "sclOut in reset", sclOut, 1);
    check({lowStart, highStart, samplePt} == 3'b0, "R1", "strobes in reset",
          {lowStart, highStart, samplePt}, 0);
    rstN = 1'b1;
    strobes = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (lowStart || highStart || samplePt || !sclOut) strobes++;
    end
    check(strobes == 0, "R1", "idle after reset (baud zero)", strobes, 0);

    // table of timing vectors
    for (int v = 0; v < NVEC; v++) begin
      tag = (VEC[v][0] == 0) ? "R3" : (VEC[v][0] == 2) ? "R5" : "R4";
      wr(2'd0, 32'd0);
      wr(2'd1, {30'h2AAAAAAA, VEC[v][0][1:0]});        // R10: upper bits ignored
      wr(2'd0, {16'hC3C3, VEC[v][1][15:0]});           // R10: upper bits ignored
      measure(lo, hi, hsIdx, spIdx, nHs, nSp, nLs);
      check(lo == VEC[v][2], tag, "low length", lo, VEC[v][2]);
      check(hi == VEC[v][3], tag, "high length", hi, VEC[v][3]);
      check(hsIdx == 0 && nHs == 1, "R6", "highStart on first high cycle", hsIdx, 0);
      check(nLs == 1, "R6", "lowStart once per period", nLs, 1);
      check(spIdx == VEC[v][4] && nSp == 1, "R7", "sample index", spIdx, VEC[v][4]);
    end

    // R8 and R9: clock stretching with setup delay
    stretchTest(2, 3, "R8");
    stretchTest(0, 3, "R9");
    stretchTest(5, 1, "R8");

    // R2: clearing the baud count mid-period parks the line
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'd6);
    while (!lowStart) @(negedge clk);
    @(negedge clk);
    wr(2'd0, 32'd0);
    @(negedge clk);
    strobes = 0;
    for (int k = 0; k < 30; k++) begin
      if (lowStart || highStart || samplePt || !sclOut) strobes++;
      @(negedge clk);
    end
    check(strobes == 0, "R2", "parked after baud zero", strobes, 0);
    check(sclOut == 1'b1, "R2", "line released when parked", sclOut, 1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule